// File: doc/BRIEF.md
# CD Serial Audio-Data Byte Receiver

This block takes the three-wire serial stream that a CD servo/signal-processing chip emits (bit clock, data, left/right word clock) together with that chip's per-sample C2 error pointer. It turns each 16-bit sample into two bytes, and each byte carries its own error flag. The bytes go to a buffer writer as a stream with single-cycle valid strobes in the system clock domain. The serial inputs are never used as clocks. They are brought into the system clock through synchronisers, and their edges are detected there.

A set of static configuration inputs adapts the receiver to the attached chip: the bit-clock edge that strobes data, the word-clock level that marks the left channel, the number of bit clocks in each word (16, 24 or 32), the bit order inside a sample, and the byte order. The byte-order setting also decides which byte the C2 flag of each word half refers to. Configuration is changed only while the receiver is idle, and the first word after a change is discarded by the user.

Top module: `cd_serial_rx`

## Requirements
- R1: While reset is high and in the cycles following it, `out_valid` and `out_err` are low and `out_byte` is zero; `out_err` is never high while `out_valid` is low.
- R2: Data and C2 are sampled on the rising bit-clock edge when `cfg_rise_edge` is 1 and on the falling edge when it is 0.
- R3: A word is tagged left (`out_left`=1) when the word clock is low and `cfg_left_on_low` is 1, or when the word clock is high and `cfg_left_on_low` is 0; both bytes of a word carry the same tag.
- R4: `cfg_word_mode` sets the bit clocks per word: 00 selects 16, 01 selects 24, 10 and 11 select 32. The sample is taken from the last 16 bit clocks of the word, counted from the word-clock change (clock positions N-16 to N-1 with the first clock after the change as position 0).
- R5: Data and C2 values on the bit clocks before position N-16 have no effect on the output bytes or their error flags.
- R6: With `cfg_lsb_first`=1 the first captured bit is sample bit 0; with 0 it is sample bit 15.
- R7: The upper byte is sample bits 15..8 and the lower byte is bits 7..0. With `cfg_low_first`=1 the lower byte is output first, otherwise the upper byte. The first output byte's error flag is the OR of C2 over captured bits 0..7, and the second byte's flag is the OR over captured bits 8..15.
- R8: Each completed word yields exactly two bytes, on two consecutive cycles, each with a one-cycle `out_valid`.
- R9: A word that the word clock cuts short before its N-th bit clock produces no bytes.
- R10: After reset no bytes are produced until the word clock has changed level at a sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rise_edge | input | 1 | 1: sample on rising bit-clock edge, 0: falling |
| cfg_left_on_low | input | 1 | 1: word clock low marks left channel, 0: high marks left |
| cfg_word_mode | input | 2 | Bit clocks per word: 00=16, 01=24, 1x=32 |
| cfg_lsb_first | input | 1 | 1: sample arrives LSB first, 0: MSB first |
| cfg_low_first | input | 1 | 1: lower byte output first, 0: upper byte first |
| sd_bclk | input | 1 | Serial bit clock from the CD signal processor |
| sd_data | input | 1 | Serial data |
| sd_lrck | input | 1 | Left/right word clock |
| sd_c2 | input | 1 | C2 error pointer, active high |
| out_byte | output | 8 | Received byte |
| out_valid | output | 1 | One-cycle strobe qualifying the byte |
| out_err | output | 1 | Error flag for the byte on `out_byte` |
| out_left | output | 1 | 1 when the byte belongs to the left channel |

## Verification
The first byte of a word appears a fixed few system cycles (two synchroniser stages, the slicer register and the output register) after the sampling edge of the word's last bit. The second byte follows exactly one cycle later. A monitor running on falling clock edges records every strobed byte and its cycle number, so the bench compares content after each word has settled and checks the one-cycle spacing of each pair exactly. Ignored-input cases (leading bit clocks, short words, pre-lock clocks) are judged by the count and content of the bytes that reach the output.

// File: rtl/cdrx_pkg.sv
package cdrx_pkg;
  localparam int SAMPLE_W = 16;
  localparam int BYTE_W   = SAMPLE_W / 2;
  localparam int IDX_W    = $clog2(2 * SAMPLE_W) + 1;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef struct packed {
    logic [SAMPLE_W-1:0] smp;
    logic                err_a;
    logic                err_b;
    logic                left;
  } word_t;

  // Bit clocks per word for the two-bit mode field.
  function automatic logic [IDX_W-1:0] word_clocks(input logic [1:0] mode);
    case (mode)
      2'b00:   return IDX_W'(SAMPLE_W);
      2'b01:   return IDX_W'(SAMPLE_W + BYTE_W);
      default: return IDX_W'(2 * SAMPLE_W);
    endcase
  endfunction
endpackage

// File: rtl/cdrx_sync.sv
module cdrx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdrx_slicer.sv
module cdrx_slicer
  import cdrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk,
  input  logic       data,
  input  logic       lrck,
  input  logic       c2,
  input  logic       cfg_rise_edge,
  input  logic       cfg_left_on_low,
  input  logic [1:0] cfg_word_mode,
  input  logic       cfg_lsb_first,
  output logic       word_done,
  output word_t      word
);
  logic             bclk_prev;
  logic             lr_last;
  logic             locked;
  logic [IDX_W-1:0] idx;

  logic             samp_edge;
  logic             lr_change;
  logic [IDX_W-1:0] n_clk;
  logic [IDX_W-1:0] first_cap;
  logic [IDX_W-1:0] k_now;
  logic [IDX_W-1:0] pos;
  logic             capture;

  always_comb begin
    samp_edge = cfg_rise_edge ? (bclk & ~bclk_prev) : (~bclk & bclk_prev);
    lr_change = (lrck != lr_last);
    n_clk     = word_clocks(cfg_word_mode);
    first_cap = n_clk - IDX_W'(SAMPLE_W);
    if (lr_change)            k_now = '0;
    else if (idx == IDX_MAX)  k_now = idx;
    else                      k_now = idx + 1'b1;
    pos     = k_now - first_cap;
    capture = samp_edge && (locked || lr_change) &&
              (k_now >= first_cap) && (k_now < n_clk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_prev <= 1'b0;
      lr_last   <= 1'b0;
      locked    <= 1'b0;
      idx       <= '0;
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      bclk_prev <= bclk;
      word_done <= 1'b0;
      if (samp_edge) begin
        idx     <= k_now;
        lr_last <= lrck;
        if (lr_change) locked <= 1'b1;
      end
      if (capture) begin
        if (cfg_lsb_first) word.smp <= {data, word.smp[SAMPLE_W-1:1]};
        else               word.smp <= {word.smp[SAMPLE_W-2:0], data};
        if (pos == '0) begin
          word.err_a <= c2;
          word.err_b <= 1'b0;
        end else if (pos < IDX_W'(BYTE_W)) begin
          word.err_a <= word.err_a | c2;
        end else begin
          word.err_b <= word.err_b | c2;
        end
        word.left <= cfg_left_on_low ? ~lrck : lrck;
        word_done <= (k_now == n_clk - 1'b1);
      end
    end
  end
endmodule

// File: rtl/cdrx_byte_out.sv
module cdrx_byte_out
  import cdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  word_t             word,
  input  logic              cfg_low_first,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              out_err,
  output logic              out_left
);
  logic              pending;
  logic [BYTE_W-1:0] pend_byte;
  logic              pend_err;
  logic [BYTE_W-1:0] hi_byte;
  logic [BYTE_W-1:0] lo_byte;

  assign hi_byte = word.smp[SAMPLE_W-1:BYTE_W];
  assign lo_byte = word.smp[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      pend_byte <= '0;
      pend_err  <= 1'b0;
      out_byte  <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_left  <= 1'b0;
    end else if (word_done) begin
      out_byte  <= cfg_low_first ? lo_byte : hi_byte;
      out_err   <= word.err_a;
      out_left  <= word.left;
      out_valid <= 1'b1;
      pend_byte <= cfg_low_first ? hi_byte : lo_byte;
      pend_err  <= word.err_b;
      pending   <= 1'b1;
    end else if (pending) begin
      out_byte  <= pend_byte;
      out_err   <= pend_err;
      out_valid <= 1'b1;
      pending   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end
  end
endmodule

// File: rtl/cd_serial_rx.sv
module cd_serial_rx
  import cdrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rise_edge,
  input  logic              cfg_left_on_low,
  input  logic [1:0]        cfg_word_mode,
  input  logic              cfg_lsb_first,
  input  logic              cfg_low_first,
  input  logic              sd_bclk,
  input  logic              sd_data,
  input  logic              sd_lrck,
  input  logic              sd_c2,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              out_err,
  output logic              out_left
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] syn_in;
  logic            word_done;
  word_t           word;

  assign raw_in = {sd_bclk, sd_data, sd_lrck, sd_c2};

  cdrx_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  cdrx_slicer u_slicer (
    .clk             (clk),
    .rst             (rst),
    .bclk            (syn_in[3]),
    .data            (syn_in[2]),
    .lrck            (syn_in[1]),
    .c2              (syn_in[0]),
    .cfg_rise_edge   (cfg_rise_edge),
    .cfg_left_on_low (cfg_left_on_low),
    .cfg_word_mode   (cfg_word_mode),
    .cfg_lsb_first   (cfg_lsb_first),
    .word_done       (word_done),
    .word            (word)
  );

  cdrx_byte_out u_out (
    .clk           (clk),
    .rst           (rst),
    .word_done     (word_done),
    .word          (word),
    .cfg_low_first (cfg_low_first),
    .out_byte      (out_byte),
    .out_valid     (out_valid),
    .out_err       (out_err),
    .out_left      (out_left)
  );
endmodule

// File: rtl/cd_serial_rx_checker.sv
module cd_serial_rx_checker (
  input logic clk,
  input logic rst,
  input logic word_done,
  input logic out_valid,
  input logic out_err,
  input logic out_left
);
  // R8: a finished word yields a strobe on each of the next two cycles
  a_r8_pair_follows: assert property (@(posedge clk) disable iff (rst)
    word_done |=> out_valid ##1 out_valid);

  // R8: no third strobe right after a pair
  a_r8_no_triple: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |=> !out_valid);

  // R8: words cannot complete on adjacent cycles
  a_r8_done_isolated: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);

  // R1: error flag only accompanies a valid byte
  a_r1_err_qualified: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_err);

  // R3: both bytes of a pair carry the same channel tag
  a_r3_pair_channel: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> (out_left == $past(out_left)));
endmodule

bind cd_serial_rx cd_serial_rx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_done (word_done),
  .out_valid (out_valid),
  .out_err   (out_err),
  .out_left  (out_left)
);

// File: tb/cd_serial_rx_bench.sv
module cd_serial_rx_bench;
  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_rise_edge = 1'b1;
  logic       cfg_left_on_low = 1'b0;
  logic [1:0] cfg_word_mode = 2'b00;
  logic       cfg_lsb_first = 1'b0;
  logic       cfg_low_first = 1'b0;
  logic       sd_bclk = 1'b0;
  logic       sd_data = 1'b0;
  logic       sd_lrck = 1'b0;
  logic       sd_c2 = 1'b0;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       out_err;
  logic       out_left;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rx_n = 0;
  logic [7:0] rx_b [16];
  logic       rx_e [16];
  logic       rx_l [16];
  int         rx_t [16];

  always #2 clk = ~clk;

  cd_serial_rx u_cd_serial_rx (
    .clk(clk), .rst(rst),
    .cfg_rise_edge(cfg_rise_edge), .cfg_left_on_low(cfg_left_on_low),
    .cfg_word_mode(cfg_word_mode), .cfg_lsb_first(cfg_lsb_first),
    .cfg_low_first(cfg_low_first),
    .sd_bclk(sd_bclk), .sd_data(sd_data), .sd_lrck(sd_lrck), .sd_c2(sd_c2),
    .out_byte(out_byte), .out_valid(out_valid), .out_err(out_err), .out_left(out_left)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && out_valid && rx_n < 16) begin
      rx_b[rx_n] = out_byte;
      rx_e[rx_n] = out_err;
      rx_l[rx_n] = out_left;
      rx_t[rx_n] = cyc;
      rx_n = rx_n + 1;
    end
  end

  // mode[41:40] rise[39] lol[38] lsb[37] lowfirst[36] c2{la,lb,ra,rb}[35:32] left[31:16] right[15:0]
  localparam logic [41:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 16'hA55A, 16'h3CC3},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, 16'h1234, 16'h5678},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0110, 16'h8001, 16'h7FFE},
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0001, 16'hDEAD, 16'hBEEF},
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1111, 16'h0F0F, 16'hF0F0},
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0100, 16'hC0DE, 16'hFACE},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0010, 16'h0001, 16'h8000},
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1001, 16'hFFFF, 16'h0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic r, input logic lol,
                         input logic lsb, input logic lf);
    cfg_word_mode = m; cfg_rise_edge = r; cfg_left_on_low = lol;
    cfg_lsb_first = lsb; cfg_low_first = lf;
    sd_bclk = r ? 1'b0 : 1'b1;
    tick(10);
  endtask

  task automatic send_bit(input logic d, input logic c, input logic lr);
    sd_data = d; sd_c2 = c; sd_lrck = lr;
    tick(H);
    sd_bclk = ~sd_bclk;
    tick(H);
    sd_bclk = ~sd_bclk;
  endtask

  function automatic int nclk(input logic [1:0] m);
    return (m == 2'b00) ? 16 : (m == 2'b01) ? 24 : 32;
  endfunction

  // Sends nb bit clocks of a word; leading clocks carry data=1 and C2=1.
  task automatic send_word(input int nb, input int n, input logic [15:0] s,
                           input logic lr, input logic ea, input logic eb);
    for (int k = 0; k < nb; k++) begin
      if (k < n - 16) send_bit(1'b1, 1'b1, lr);
      else begin
        int j = k - (n - 16);
        send_bit(cfg_lsb_first ? s[j] : s[15 - j], (j < 8) ? ea : eb, lr);
      end
    end
  endtask

  task automatic exp_word(input int v, input int base, input logic [15:0] s,
                          input logic ea, input logic eb, input logic lf, input logic left);
    logic [7:0] b0 = lf ? s[7:0] : s[15:8];
    logic [7:0] b1 = lf ? s[15:8] : s[7:0];
    chk($sformatf("R2/R4/R6/R7 vec %0d byte %0d", v, base), rx_b[base], b0);
    chk($sformatf("R2/R4/R6/R7 vec %0d byte %0d", v, base + 1), rx_b[base+1], b1);
    chk($sformatf("R5/R7 err vec %0d byte %0d", v, base), rx_e[base], ea);
    chk($sformatf("R5/R7 err vec %0d byte %0d", v, base + 1), rx_e[base+1], eb);
    chk($sformatf("R3 channel vec %0d byte %0d", v, base), rx_l[base], left);
    chk($sformatf("R3 channel vec %0d byte %0d", v, base + 1), rx_l[base+1], left);
    chk($sformatf("R8 spacing vec %0d word %0d", v, base / 2), rx_t[base+1] - rx_t[base], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    // R1: reset state
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 out_byte in reset", out_byte, 0);
    chk("R1 out_err in reset", out_err, 0);
    rst = 1'b0;
    tick(3);
    chk("R1 out_valid after reset", out_valid, 0);

    // R10: clocks without any word-clock change give nothing
    set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    send_word(40, 16, 16'h5555, 1'b0, 1'b0, 1'b0);
    tick(20);
    chk("R10 bytes before first LR change", rx_n, 0);

    // Table-driven main function
    for (int v = 0; v < 8; v++) begin
      logic [41:0] e = VEC[v];
      int n = nclk(e[41:40]);
      logic lvl_l;
      set_cfg(e[41:40], e[39], e[38], e[37], e[36]);
      lvl_l = e[38] ? 1'b0 : 1'b1;
      send_word(n, n, 16'h0000, ~lvl_l, 1'b0, 1'b0);
      tick(20);
      rx_n = 0;
      send_word(n, n, e[31:16], lvl_l, e[35], e[34]);
      send_word(n, n, e[15:0], ~lvl_l, e[33], e[32]);
      tick(20);
      chk($sformatf("R8 byte count vec %0d", v), rx_n, 4);
      if (rx_n >= 4) begin
        exp_word(v, 0, e[31:16], e[35], e[34], e[36], 1'b1);
        exp_word(v, 2, e[15:0], e[33], e[32], e[36], 1'b0);
      end
    end

    // R9: a word cut short yields nothing, the following full word does
    set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    send_word(16, 16, 16'h0000, 1'b0, 1'b0, 1'b0);
    tick(20);
    rx_n = 0;
    send_word(10, 16, 16'hFFFF, 1'b1, 1'b0, 1'b0);
    send_word(16, 16, 16'h1357, 1'b0, 1'b1, 1'b0);
    tick(20);
    chk("R9 bytes after short word", rx_n, 2);
    if (rx_n >= 2) begin
      chk("R9 first byte", rx_b[0], 8'h13);
      chk("R9 second byte", rx_b[1], 8'h57);
      chk("R9 channel", rx_l[0], 0);
    end

    // R5: 32-clock word whose leading clocks all carry data=1 and C2=1
    set_cfg(2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
    send_word(32, 32, 16'h0000, 1'b0, 1'b0, 1'b0);
    tick(20);
    rx_n = 0;
    send_word(32, 32, 16'h0000, 1'b1, 1'b0, 1'b0);
    tick(20);
    chk("R5 byte count", rx_n, 2);
    if (rx_n >= 2) begin
      chk("R5 upper byte unaffected", rx_b[0], 8'h00);
      chk("R5 lower byte unaffected", rx_b[1], 8'h00);
      chk("R5 error flag unaffected", rx_e[0] | rx_e[1], 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule